// File: doc/BRIEF.md
# Two-Wire Bus Interrupt Vector Encoder

This block gathers the event pulses of a two-wire bus controller into sticky status flags, masks them with an enable register and drives one interrupt line. A vector register reports the most urgent pending event that is also enabled, as a small numeric code. Each source has a fixed code, and a lower code means higher urgency.

Reading the vector register acknowledges the event it reports by clearing that flag. An interrupt handler therefore reads the vector over and over, handling each code, until it reads zero. Software can also clear status flags directly by writing ones to them. The register port is a simple one-cycle strobe interface. Read data is combinational from the current state, and every state change takes effect at the clock edge that samples the strobe.

Top module: `twb_irq_vector`

## Requirements
- R1: Each source sets a sticky status flag that appears in the status register (offset 0). Source 0 (arbitration lost) is at bit 0, source 1 (no-acknowledge) at bit 1, source 2 (access ready) at bit 2, source 3 (receive ready) at bit 3, source 4 (transmit ready) at bit 4, source 5 (stop detected) at bit 5 and source 6 (addressed as slave) at bit 9. All other bits read zero.
- R2: The enable register (offset 1) holds one bit per source, with source k at bit k for k = 0..6. Writes to it read back, and upper bits read zero.
- R3: The vector register (offset 2) returns code k+1 in bits 2:0 for source k. It returns 0 when no flag is both pending and enabled. Flags that are pending but disabled are never reported.
- R4: When several enabled flags are pending, the vector reports the lowest code.
- R5: A read of the vector register clears the flag it reports, at the clock edge of the read. Successive reads step through the pending enabled events in code order and end at 0.
- R6: Writing the status register clears every flag whose bit is 1 in the write data. Bits written as 0 leave their flags unchanged.
- R7: irq_o is high exactly while some flag is both pending and enabled. It goes low in the cycle after the edge that clears the last such flag.
- R8: An event pulse in the same cycle as a clearing vector read or status write of that flag leaves the flag set.
- R9: Vector read data bits 15:3 are zero, and this includes the test-mode field at bits 11:8.
- R10: After reset all flags and enables are zero, the vector reads 0 and irq_o is low.
- R11: Reading the status register, or reading the vector while it is 0, changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | One-cycle event pulses, one per source, in code order |
| reg_addr_i | input | 2 | Register offset: 0 status, 1 enable, 2 vector |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (acknowledges on the vector offset) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current offset, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse, register write or acknowledging read acts at the clock edge that samples it. The resulting status, vector and interrupt values are visible from that edge until the next one. Read data belongs to the cycle of the strobe and shows the state before that strobe's effect. The bench drives every input 1 ns after a rising edge and samples read data in the same cycle. It samples irq_o and the effect of a clear only after one further edge, so each check lands in the single cycle its result is due.

// File: rtl/twb_irq_pkg.sv
package twb_irq_pkg;
  localparam int unsigned NUM_SRC  = 7;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_EN   = 1;
  localparam int unsigned OFS_VEC  = 2;
  // test-mode field of the vector register, always zero
  localparam int unsigned TM_LSB   = 8;
  localparam int unsigned TM_W     = 4;

  // status bit of a source: first six packed low, the rest moved up by three
  function automatic int unsigned stat_pos(int unsigned src);
    return (src < 6) ? src : src + 3;
  endfunction
endpackage

// File: rtl/twb_irq_flags.sv
module twb_irq_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set wins over clear so a coincident event is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_i[g]);
    end

    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
    p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[g] && !set_i[g]) |=> $stable(flag_q[g]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/twb_irq_prio.sv
module twb_irq_prio #(
  parameter int unsigned N      = 7,
  parameter int unsigned CODE_W = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N-1:0]      sel_o
);
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o   = CODE_W'(i + 1);
        sel_o    = '0;
        sel_o[i] = 1'b1;
      end
    end
  end

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_code_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != '0) |-> req_i[code_o - 1'b1]);
  p_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (code_o == '0));
endmodule

// File: rtl/twb_irq_regs.sv
module twb_irq_regs
  import twb_irq_pkg::*;
#(
  parameter int unsigned N      = 7,
  parameter int unsigned DW     = 16,
  parameter int unsigned AW     = 2,
  parameter int unsigned CODE_W = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N-1:0]      flag_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      w1c_o,
  output logic              vec_rd_o,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
  localparam logic [AW-1:0] A_VEC  = AW'(OFS_VEC);

  logic [N-1:0]  en_q;
  logic [DW-1:0] stat_img;
  logic [DW-1:0] vec_img;
  logic          stat_wr;
  logic          en_wr;

  assign stat_wr  = wr_i && (addr_i == A_STAT);
  assign en_wr    = wr_i && (addr_i == A_EN);
  assign vec_rd_o = rd_i && (addr_i == A_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= wdata_i[N-1:0];
  end

  always_comb begin
    stat_img = '0;
    w1c_o    = '0;
    for (int i = 0; i < N; i++) begin
      stat_img[stat_pos(i)] = flag_i[i];
      w1c_o[i]              = stat_wr && wdata_i[stat_pos(i)];
    end
  end

  always_comb begin
    vec_img = '0;
    vec_img[CODE_W-1:0] = code_i;
    vec_img[TM_LSB +: TM_W] = '0;
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = stat_img;
      A_EN:    rdata_o = DW'(en_q);
      A_VEC:   rdata_o = vec_img;
      default: rdata_o = '0;
    endcase
  end

  assign en_o = en_q;

  p_en_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> (en_o == $past(wdata_i[N-1:0])));
  p_vec_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_VEC) |-> (rdata_o[DW-1:CODE_W] == '0));
  p_w1c_only_on_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |-> (w1c_o == '0));
endmodule

// File: rtl/twb_irq_vector.sv
module twb_irq_vector
  import twb_irq_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam int unsigned CODE_W = $clog2(N + 1);

  logic [N-1:0]      flag;
  logic [N-1:0]      en;
  logic [N-1:0]      pend;
  logic [N-1:0]      sel;
  logic [N-1:0]      w1c;
  logic [N-1:0]      clr;
  logic [CODE_W-1:0] code;
  logic              vec_rd;

  twb_irq_flags #(.N(N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr),
    .flag_o (flag)
  );

  assign pend = flag & en;

  twb_irq_prio #(.N(N), .CODE_W(CODE_W)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pend),
    .code_o (code),
    .sel_o  (sel)
  );

  twb_irq_regs #(.N(N), .DW(DW), .AW(AW), .CODE_W(CODE_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .wdata_i  (reg_wdata_i),
    .flag_i   (flag),
    .code_i   (code),
    .en_o     (en),
    .w1c_o    (w1c),
    .vec_rd_o (vec_rd),
    .rdata_o  (reg_rdata_o)
  );

  // acknowledge: the read clears only the reported source
  assign clr   = w1c | (vec_rd ? sel : '0);
  assign irq_o = |pend;

  p_irq_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (code != '0));
  p_irq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && !reg_wr_i && $countones(pend) == 1 && evt_i == '0) |=> !irq_o);
  p_ack_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd |-> $onehot0(clr));
endmodule

// File: tb/twb_irq_vector_bench.sv
`timescale 1ns/1ps
module twb_irq_vector_bench;
  localparam int unsigned N = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twb_irq_vector u_twb_irq_vector (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .evt_i       (evt),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(logic [6:0] m);
    evt = m; step(); evt = '0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; step(); wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1; #1; d = rdata; step(); rd = 1'b0;
  endtask

  // peek without strobe: combinational view of current state
  task automatic peek(logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(0, v); check("R10 status after reset", v, 16'h0000);
    peek(1, v); check("R10 enable after reset", v, 16'h0000);
    peek(2, v); check("R10 vector after reset", v, 16'h0000);
    check("R10 irq after reset", 16'(irq), 16'h0);
  endtask

  task automatic t_enable_rw();
    logic [15:0] v;
    reg_write(1, 16'h0055); peek(1, v); check("R2 enable readback", v, 16'h0055);
    reg_write(1, 16'hFFFF); peek(1, v); check("R2 enable upper bits zero", v, 16'h007F);
    reg_write(1, 16'h0000);
  endtask

  task automatic t_layout();
    logic [15:0] v;
    for (int k = 0; k < 7; k++) begin
      pulse(7'(1 << k));
      peek(0, v);
      check($sformatf("R1 status pos src%0d", k), v, 16'(1 << (k < 6 ? k : 9)));
      reg_write(0, 16'h023F);
    end
    pulse(7'h7F);
    peek(0, v); check("R1 status all", v, 16'h023F);
    peek(2, v); check("R3 disabled not reported", v, 16'h0000);
    check("R7 irq low when disabled", 16'(irq), 16'h0);
    reg_read(0, v); peek(0, v); check("R11 status read keeps flags", v, 16'h023F);
    reg_write(0, 16'h023F);
  endtask

  task automatic t_drain();
    logic [15:0] v;
    reg_write(1, 16'h007F);
    pulse(7'h7F);
    check("R7 irq high with pending", 16'(irq), 16'h1);
    for (int k = 1; k <= 7; k++) begin
      if (k == 7) check("R7 irq still high during last ack", 16'(irq), 16'h1);
      reg_read(2, v);
      check($sformatf("R5 R4 drain code %0d", k), v, 16'(k));
    end
    check("R7 irq low after last ack", 16'(irq), 16'h0);
    reg_read(2, v); check("R5 drain ends at zero", v, 16'h0000);
    peek(0, v); check("R5 status empty after drain", v, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    reg_write(1, 16'h0014);           // enable sources 2 and 4
    pulse(7'h17);                     // pend 0,1,2,4
    reg_read(2, v); check("R3 R4 masked priority", v, 16'h0003);
    reg_read(2, v); check("R4 next enabled", v, 16'h0005);
    reg_read(2, v); check("R3 masked ones never reported", v, 16'h0000);
    peek(0, v); check("R11 masked flags survive", v, 16'h0003);
    reg_write(1, 16'h0002);
    peek(2, v); check("R3 enabling reveals flag", v, 16'h0002);
    reg_write(0, 16'h023F); reg_write(1, 16'h0000);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    pulse(7'h24);                     // sources 2 and 5
    reg_write(0, 16'h0000); peek(0, v); check("R6 write zero no effect", v, 16'h0024);
    reg_write(0, 16'h0004); peek(0, v); check("R6 w1c access ready", v, 16'h0020);
    pulse(7'h40);
    reg_write(0, 16'h0040); peek(0, v); check("R6 bit6 not a flag", v, 16'h0220);
    reg_write(0, 16'h0220); peek(0, v); check("R6 w1c stop and slave", v, 16'h0000);
  endtask

  task automatic t_coincide();
    logic [15:0] v;
    reg_write(1, 16'h007F);
    pulse(7'h08);
    check("R7 irq one flag", 16'(irq), 16'h1);
    evt = 7'h08; reg_read(2, v); evt = '0;
    check("R8 read code", v, 16'h0004);
    peek(2, v); check("R8 coincident event kept", v, 16'h0004);
    check("R8 irq stays", 16'(irq), 16'h1);
    evt = 7'h08; reg_write(0, 16'h0008); evt = '0;
    peek(0, v); check("R8 coincident with w1c kept", v, 16'h0008);
    reg_read(2, v);
    check("R7 irq drops next cycle", 16'(irq), 16'h0);
    reg_read(2, v); check("R11 zero read harmless", v, 16'h0000);
    peek(0, v); check("R11 status after zero read", v, 16'h0000);
    reg_write(1, 16'h0000);
  endtask

  task automatic t_vec_upper();
    logic [15:0] v;
    reg_write(1, 16'h007F);
    pulse(7'h40);
    peek(2, v);
    check("R9 code bits", v & 16'h0007, 16'h0007);
    check("R9 test mode and upper zero", v & 16'hFFF8, 16'h0000);
    reg_read(2, v);
    reg_write(1, 16'h0000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_enable_rw();
    t_layout();
    t_drain();
    t_mask();
    t_w1c();
    t_coincide();
    t_vec_upper();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule